// File: doc/BRIEF.md
# SPI Control Register Bank

This block is a serial slave that gives a host access to a small bank of 16-bit control registers over a 4-wire SPI link in mode 0. The link idles with its clock low, the slave samples on the rising clock edge, and it changes its output on the falling edge. Every transaction is a fixed 24-bit frame. The two most significant bits of each frame set its kind. When they are zero, the frame is a register access: the frame carries a register address, a read/write flag and 16 data bits. When they are non-zero, the frame is a raw gain or attenuator command. Such a frame bypasses the bank and is handed on whole, as a 24-bit word, to a separate command port.

The register contents drive static control outputs, such as RF switch selects and filter selects, through a flat registered output vector. Two of these outputs are the receive and transmit high-band table-select bits. A scratch register lets software run a write/read loopback test. All SPI inputs are synchronised into the system clock domain, so the serial clock must be well below the system clock; the bench uses one sixteenth of it.

Top module: `spi_ctl_bank`

## Requirements
- R1: After a synchronous reset, register 5 and register 6 are 0x0000. Every other implemented address i (0..NREG-1, NREG=8 by default) holds 0x1000+i. spi_miso is 0 and gain_vld is 0.
- R2: A 24-bit frame has bits 23:22 = 00 and bit 16 = 0. Bits 23:17 form the address A and bits 15:0 the data D; the frame is sent MSB first. For such a frame with A < NREG, register A takes D (masked per R4) after chip select rises.
- R3: The scratch register at address 0x05 stores all 16 bits. Any value written there reads back unchanged.
- R4: The table-select register at address 0x06 keeps only bit 0 (receive high band, driven on rx_tbl_hi) and bit 1 (transmit high band, driven on tx_tbl_hi). Its bits 15:2 always read 0.
- R5: A frame with bits 23:22 = 00 and bit 16 = 1 is a read. During the same frame, spi_miso shifts out 8 zero bits and then register A, MSB first. The master samples each bit before the rising edge that carries the matching input bit. A read changes no register. spi_miso is 0 while chip select is high.
- R6: A frame with bits 23:22 non-zero appears on gain_cmd as the full 24-bit word, with gain_vld high for exactly one clock. Such a frame writes no register, and spi_miso stays 0 during it, whatever bit 16 holds.
- R7: A frame is discarded if chip select was low for any number of rising clock edges other than 24. A discarded frame writes no register and raises no gain_vld.
- R8: Writes to addresses NREG..31 are ignored, and reads of those addresses return 0.
- R9: ctrl_regs[16*i+15:16*i] always equals the current content of register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| ctrl_regs | output | NREG*16 | All register contents, register i in bits 16*i+15:16*i |
| rx_tbl_hi | output | 1 | Receive high-band table select (register 6 bit 0) |
| tx_tbl_hi | output | 1 | Transmit high-band table select (register 6 bit 1) |
| gain_cmd | output | 24 | Last forwarded gain/attenuator command word |
| gain_vld | output | 1 | One-cycle strobe marking a new gain_cmd |

## Verification
Register storage is visible at every clock on ctrl_regs, so a wrong write or a stray write shows up within a few cycles of the frame that caused it. A miscounted bit, a miscounted frame length or a wrong field decode shows up as a write to the wrong register, a missing write or a spurious gain_vld. In each case the fault is visible right after the frame ends. Read-path faults, such as a wrong header length or a wrong class test on reads, only show on spi_miso within the read frame itself. For that reason every read's returned word is compared with the reference model's register image.

// File: rtl/sbk_pkg.sv
package sbk_pkg;
  localparam int FRAME_BITS   = 24;
  localparam int DATA_W       = 16;
  localparam int ADDR_W       = 7;
  localparam int CLASS_W      = 2;
  localparam int RD_BIT       = 16;
  localparam int HDR_BITS     = FRAME_BITS - DATA_W;
  localparam int SCRATCH_ADDR = 5;
  localparam int TBLSEL_ADDR  = 6;
  localparam logic [DATA_W-1:0] TBLSEL_MASK = 16'h0003;

  function automatic logic [DATA_W-1:0] reg_default(int idx);
    if (idx == SCRATCH_ADDR || idx == TBLSEL_ADDR) return '0;
    return DATA_W'(idx + 4096);
  endfunction

  function automatic logic [DATA_W-1:0] reg_mask(int idx);
    if (idx == TBLSEL_ADDR) return TBLSEL_MASK;
    return '1;
  endfunction
endpackage

// File: rtl/sbk_spi_front.sv
module sbk_spi_front
  import sbk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk,
  input  logic                  csn,
  input  logic                  mosi,
  input  logic [DATA_W-1:0]     rd_data,
  output logic [ADDR_W-1:0]     peek_addr,
  output logic                  frame_vld,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  miso
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS);

  logic [SYNC_STAGES-1:0] sclk_sy, csn_sy, mosi_sy;
  logic                   sclk_s, mosi_s, cs_act;
  logic                   sclk_d, cs_act_d;
  logic                   rise, fall, peek_rd, rd_ok;
  logic [FRAME_BITS-1:0]  shreg;
  logic [DATA_W-1:0]      txsh;
  logic [CNT_W-1:0]       cnt;
  logic                   miso_q;

  assign sclk_s = sclk_sy[SYNC_STAGES-1];
  assign mosi_s = mosi_sy[SYNC_STAGES-1];
  assign cs_act = ~csn_sy[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sy  <= '0;
      csn_sy   <= '1;
      mosi_sy  <= '0;
      sclk_d   <= 1'b0;
      cs_act_d <= 1'b0;
    end else begin
      sclk_sy  <= {sclk_sy[SYNC_STAGES-2:0], sclk};
      csn_sy   <= {csn_sy[SYNC_STAGES-2:0], csn};
      mosi_sy  <= {mosi_sy[SYNC_STAGES-2:0], mosi};
      sclk_d   <= sclk_s;
      cs_act_d <= cs_act;
    end
  end

  assign rise = cs_act & sclk_s & ~sclk_d;
  assign fall = cs_act & ~sclk_s & sclk_d;

  // header fields are complete once HDR_BITS rising edges have arrived
  assign peek_addr = shreg[HDR_BITS-1 -: ADDR_W];
  assign peek_rd   = shreg[HDR_BITS-1-ADDR_W];
  assign rd_ok     = peek_rd && (peek_addr[ADDR_W-1 -: CLASS_W] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      txsh      <= '0;
      cnt       <= '0;
      miso_q    <= 1'b0;
      frame_vld <= 1'b0;
      frame     <= '0;
    end else begin
      frame_vld <= 1'b0;
      if (cs_act && !cs_act_d) begin
        cnt    <= '0;
        shreg  <= '0;
        txsh   <= '0;
        miso_q <= 1'b0;
      end else if (!cs_act && cs_act_d) begin
        miso_q <= 1'b0;
        if (cnt == CNT_FULL) begin
          frame_vld <= 1'b1;
          frame     <= shreg;
        end
      end else if (cs_act) begin
        if (rise) begin
          shreg <= {shreg[FRAME_BITS-2:0], mosi_s};
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
        if (fall) begin
          if (cnt == CNT_HDR) begin
            if (rd_ok) begin
              miso_q <= rd_data[DATA_W-1];
              txsh   <= {rd_data[DATA_W-2:0], 1'b0};
            end else begin
              miso_q <= 1'b0;
              txsh   <= '0;
            end
          end else if (cnt > CNT_HDR) begin
            miso_q <= txsh[DATA_W-1];
            txsh   <= {txsh[DATA_W-2:0], 1'b0};
          end else begin
            miso_q <= 1'b0;
          end
        end
      end
    end
  end

  assign miso = miso_q;

  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!cs_act && !cs_act_d) |-> !miso_q); // R5

  AST_FRAME_ON_END: assert property (@(posedge clk) disable iff (rst)
    frame_vld |-> ($past(cs_act_d) && !$past(cs_act))); // R7
endmodule

// File: rtl/sbk_decode.sv
module sbk_decode
  import sbk_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_vld,
  input  logic [FRAME_BITS-1:0] frame,
  output logic                  wr_en,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [DATA_W-1:0]     wr_data,
  output logic                  gain_vld,
  output logic [FRAME_BITS-1:0] gain_cmd
);
  logic [ADDR_W-1:0]  f_addr;
  logic [CLASS_W-1:0] f_class;
  logic               f_rd, f_hit;

  assign f_addr  = frame[FRAME_BITS-1 -: ADDR_W];
  assign f_class = frame[FRAME_BITS-1 -: CLASS_W];
  assign f_rd    = frame[RD_BIT];
  assign f_hit   = (32'(f_addr) < 32'(NREG));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      gain_vld <= 1'b0;
      gain_cmd <= '0;
    end else begin
      wr_en    <= 1'b0;
      gain_vld <= 1'b0;
      if (frame_vld) begin
        if (f_class != '0) begin
          gain_vld <= 1'b1;
          gain_cmd <= frame;
        end else if (!f_rd && f_hit) begin
          wr_en   <= 1'b1;
          wr_addr <= f_addr;
          wr_data <= frame[DATA_W-1:0];
        end
      end
    end
  end

  AST_GAIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    gain_vld |=> !gain_vld); // R6

  AST_GAIN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    gain_vld |-> !wr_en); // R6
endmodule

// File: rtl/sbk_bank.sv
module sbk_bank
  import sbk_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NREG*DATA_W-1:0] regs_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] DFLT = reg_default(g);
    localparam logic [DATA_W-1:0] MASK = reg_mask(g);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= DFLT;
      else if (wr_en && (32'(wr_addr) == 32'(g))) q <= wr_data & MASK;
    end
    assign regs_flat[g*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (32'(rd_addr) == 32'(i)) rd_data = regs_flat[i*DATA_W +: DATA_W];
    end
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (32'(wr_addr) < 32'(NREG))); // R8

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rst)) |-> $stable(regs_flat)); // R7
endmodule

// File: rtl/spi_ctl_bank.sv
module spi_ctl_bank
  import sbk_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   spi_sclk,
  input  logic                   spi_csn,
  input  logic                   spi_mosi,
  output logic                   spi_miso,
  output logic [NREG*DATA_W-1:0] ctrl_regs,
  output logic                   rx_tbl_hi,
  output logic                   tx_tbl_hi,
  output logic [FRAME_BITS-1:0]  gain_cmd,
  output logic                   gain_vld
);
  logic [ADDR_W-1:0]     peek_addr;
  logic [DATA_W-1:0]     rd_data;
  logic                  frame_vld;
  logic [FRAME_BITS-1:0] frame;
  logic                  wr_en;
  logic [ADDR_W-1:0]     wr_addr;
  logic [DATA_W-1:0]     wr_data;

  sbk_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .csn(spi_csn), .mosi(spi_mosi),
    .rd_data(rd_data), .peek_addr(peek_addr), .frame_vld(frame_vld),
    .frame(frame), .miso(spi_miso)
  );

  sbk_decode #(.NREG(NREG)) u_dec (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .frame(frame),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gain_vld(gain_vld), .gain_cmd(gain_cmd)
  );

  sbk_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(peek_addr), .rd_data(rd_data), .regs_flat(ctrl_regs)
  );

  if (NREG > TBLSEL_ADDR) begin : g_tbl
    assign rx_tbl_hi = ctrl_regs[TBLSEL_ADDR*DATA_W];
    assign tx_tbl_hi = ctrl_regs[TBLSEL_ADDR*DATA_W + 1];
  end else begin : g_no_tbl
    assign rx_tbl_hi = 1'b0;
    assign tx_tbl_hi = 1'b0;
  end

  AST_GAIN_CLASS: assert property (@(posedge clk) disable iff (rst)
    gain_vld |-> (gain_cmd[FRAME_BITS-1 -: CLASS_W] != '0)); // R6
endmodule

// File: tb/tb_spi_ctl_bank.sv
module tb_spi_ctl_bank;
  localparam int NREG = 8;
  localparam int DW   = 16;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic              miso, rx_tbl_hi, tx_tbl_hi, gain_vld;
  logic [NREG*DW-1:0] ctrl_regs;
  logic [23:0]       gain_cmd;

  always #4 clk = ~clk;

  spi_ctl_bank #(.NREG(NREG)) dut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .ctrl_regs(ctrl_regs), .rx_tbl_hi(rx_tbl_hi),
    .tx_tbl_hi(tx_tbl_hi), .gain_cmd(gain_cmd), .gain_vld(gain_vld)
  );

  int errors = 0, checks = 0, cyc = 0, gain_cnt = 0;
  int exp_regs[NREG];
  bit settle = 1'b1;
  logic [23:0] gain_last = '0;
  logic [23:0] rx;

  function automatic int dflt(int i);
    if (i == 5 || i == 6) return 0;
    return 4096 + i;
  endfunction

  function automatic int msk(int i);
    return (i == 6) ? 3 : 16'hFFFF;
  endfunction

  function automatic logic [23:0] mk(int a, bit rd, int d);
    return {7'(a), rd, 16'(d)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (gain_vld) begin
      gain_cnt++;
      gain_last = gain_cmd;
    end
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1..R9 run hung actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // per-clock comparison against the reference image (R9, R4, R5 idle)
  always @(negedge clk) begin
    if (!settle && !rst) begin
      for (int i = 0; i < NREG; i++)
        chk("R9 ctrl_regs slice", 32'(ctrl_regs[i*DW +: DW]), 32'(exp_regs[i]));
      chk("R4 table select outputs", {30'd0, tx_tbl_hi, rx_tbl_hi}, 32'(exp_regs[6] & 3));
      if (csn) chk("R5 miso idle", 32'(miso), 32'd0);
    end
  end

  task automatic xfer(input logic [23:0] w, input int nbits, output logic [23:0] r);
    r = '0;
    @(negedge clk) csn = 1'b0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      mosi = (b < 24) ? w[23-b] : 1'b0;
      repeat (8) @(negedge clk);
      r = {r[22:0], miso};
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    csn = 1'b1;
    mosi = 1'b0;
  endtask

  task automatic frame(input logic [23:0] w, input int nbits, output logic [23:0] r);
    settle = 1'b1;
    xfer(w, nbits, r);
    repeat (12) @(negedge clk);
    if (nbits == 24 && w[23:22] == 2'b00 && !w[16] && int'(w[23:17]) < NREG)
      exp_regs[w[23:17]] = int'(w[15:0]) & msk(int'(w[23:17]));
    settle = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_check(input string req, input int a);
    logic [23:0] r;
    int e;
    frame(mk(a, 1'b1, 0), 24, r);
    e = (a < NREG) ? exp_regs[a] : 0;
    chk(req, 32'(r), 32'(e));
  endtask

  task automatic do_reset();
    settle = 1'b1;
    @(negedge clk) rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NREG; i++) exp_regs[i] = dflt(i);
    @(negedge clk);
    for (int i = 0; i < NREG; i++)
      chk("R1 reset default", 32'(ctrl_regs[i*DW +: DW]), 32'(dflt(i)));
    chk("R1 miso after reset", 32'(miso), 32'd0);
    chk("R1 gain_vld after reset", 32'(gain_vld), 32'd0);
    settle = 1'b0;
  endtask

  initial begin
    int g0;
    do_reset();

    // R2: writes to plain control registers
    frame(mk(0, 1'b0, 16'h1234), 24, rx);
    frame(mk(3, 1'b0, 16'hBEEF), 24, rx);
    frame(mk(7, 1'b0, 16'h8001), 24, rx);
    chk("R2 write reg0", 32'(ctrl_regs[0 +: DW]), 32'h1234);
    chk("R2 write reg3", 32'(ctrl_regs[3*DW +: DW]), 32'hBEEF);
    chk("R2 write reg7", 32'(ctrl_regs[7*DW +: DW]), 32'h8001);

    // R5: read-back of written and default registers
    rd_check("R5 read reg0", 0);
    rd_check("R5 read reg3", 3);
    rd_check("R5 read reg1 default", 1);

    // R3: scratch loopback
    frame(mk(5, 1'b0, 16'hA5C3), 24, rx);
    rd_check("R3 scratch A5C3", 5);
    frame(mk(5, 1'b0, 16'hFFFF), 24, rx);
    rd_check("R3 scratch FFFF", 5);
    frame(mk(5, 1'b0, 16'h0000), 24, rx);
    rd_check("R3 scratch 0000", 5);

    // R4: table-select masking
    frame(mk(6, 1'b0, 16'hFFFF), 24, rx);
    rd_check("R4 tblsel masked read", 6);
    chk("R4 tblsel both high", {30'd0, tx_tbl_hi, rx_tbl_hi}, 32'd3);
    frame(mk(6, 1'b0, 16'h0001), 24, rx);
    chk("R4 rx only", {30'd0, tx_tbl_hi, rx_tbl_hi}, 32'd1);
    frame(mk(6, 1'b0, 16'hFFFE), 24, rx);
    chk("R4 tx only", {30'd0, tx_tbl_hi, rx_tbl_hi}, 32'd2);

    // R6: gain command forwarding
    g0 = gain_cnt;
    frame(24'h4A2040, 24, rx);
    chk("R6 gain strobe count class1", 32'(gain_cnt - g0), 32'd1);
    chk("R6 gain word class1", 32'(gain_last), 32'h4A2040);
    chk("R6 miso zero class1", 32'(rx), 32'd0);
    g0 = gain_cnt;
    frame(24'h9E2040, 24, rx);
    chk("R6 gain word class2", 32'(gain_last), 32'h9E2040);
    frame(24'hFFFFFF, 24, rx);
    chk("R6 gain word class3 rdflag", 32'(gain_last), 32'hFFFFFF);
    chk("R6 miso zero rdflag", 32'(rx), 32'd0);
    chk("R6 gain strobe count two", 32'(gain_cnt - g0), 32'd2);

    // R7: wrong-length frames
    g0 = gain_cnt;
    frame(mk(1, 1'b0, 16'hDEAD), 23, rx);
    frame(mk(1, 1'b0, 16'hDEAD), 25, rx);
    frame(24'h4A2040, 23, rx);
    frame(24'h4A2040, 25, rx);
    chk("R7 short/long no gain", 32'(gain_cnt - g0), 32'd0);
    chk("R7 reg1 unchanged", 32'(ctrl_regs[1*DW +: DW]), 32'h1001);
    rd_check("R7 reg1 readback", 1);

    // R8: unused addresses
    frame(mk(9, 1'b0, 16'h5555), 24, rx);
    frame(mk(31, 1'b0, 16'hAAAA), 24, rx);
    rd_check("R8 read addr9", 9);
    rd_check("R8 read addr31", 31);
    rd_check("R8 reg7 intact", 7);

    // R1: reset mid-run restores defaults
    frame(mk(2, 1'b0, 16'h0F0F), 24, rx);
    do_reset();
    rd_check("R1 reg2 default after reset", 2);

    repeat (20) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule